// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block takes eight interrupt request lines and decides whether, and for which line, a single interrupt output should be raised toward a processor. It holds three per-line state vectors: requests that have been latched, requests that are being serviced, and a blocking mask. It also holds a per-line trigger mode (edge or level) and a rotating priority base. Priority is a ring: the line at the base position ranks highest and rank falls as the position walks upward, wrapping at the top.

A request wins only if it ranks strictly above everything already in service. Software-side logic, outside this block, decodes host writes into the strobes used here: an acknowledge strobe with a line index, an end-of-service command with an operation code and index, and write strobes for the mask and trigger-mode vectors. Static configuration inputs select automatic end of service on acknowledge, rotation on automatic end of service, a special mask mode, a nested-cascade mode and the master role. All state is updated on the clock edge. The interrupt output and its index are registered from the state every cycle.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset the request, in-service and mask vectors are zero, the priority base is 0, every line is in edge mode (trigger-mode bit 0), and `irq_out` is low.
- R2: In edge mode (trigger-mode bit 0) a request bit is set only by a low-to-high change of its input between two clock edges; a line held high does not set it again after it was cleared.
- R3: In level mode (trigger-mode bit 1) a request bit equals the input level sampled at the previous clock edge.
- R4: The winner is the pending line with the smallest rank k, where line (k + base) mod 8 has rank k. `irq_idx` reports that line, so with base 0 the lowest-numbered line wins.
- R5: A request whose mask bit is 1 takes no part in arbitration and cannot raise `irq_out`.
- R6: `irq_out` is raised only if the best pending rank is strictly smaller than the best in-service rank; an empty in-service vector ranks as 8.
- R7: An acknowledge clears the acknowledged request bit in edge mode and keeps it in level mode. Without auto end of service it sets the in-service bit; with auto end of service it leaves the in-service vector unchanged.
- R8: An acknowledge with auto end of service and rotation enabled sets the base to (index + 1) mod 8.
- R9: Operation 1 clears the best-ranked in-service bit and does nothing when none is set. Operation 2 does the same and also sets the base to that line + 1 (mod 8).
- R10: Operation 3 clears the in-service bit named by `cmd_idx`. Operation 4 also sets the base to `cmd_idx` + 1. Operation 5 only sets the base to `cmd_idx` + 1. Operations 0, 6 and 7 do nothing.
- R11: With special mask on, in-service bits whose mask bit is 1 are left out of the in-service rank.
- R12: With nested-cascade mode and master role both on, in-service bit 2 is left out of the in-service rank.
- R13: `irq_out` and `irq_idx` change one clock after the state they are computed from; `irq_idx` holds its value while no line wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Interrupt request input levels |
| trig_we | input | 1 | Write strobe for the trigger-mode vector |
| trig_wdata | input | 8 | New trigger modes, 1 = level, 0 = edge |
| mask_we | input | 1 | Write strobe for the mask vector |
| mask_wdata | input | 8 | New mask, 1 = line blocked |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Line being acknowledged |
| cmd_valid | input | 1 | End-of-service / priority command strobe |
| cmd_op | input | 3 | Command code, see R9 and R10 |
| cmd_idx | input | 3 | Line field of the command |
| cfg_auto_eoi | input | 1 | Automatic end of service on acknowledge |
| cfg_rot_aeoi | input | 1 | Rotate base on automatic end of service |
| cfg_special_mask | input | 1 | Special mask mode |
| cfg_nested | input | 1 | Nested-cascade mode |
| cfg_master | input | 1 | Master role |
| irq_out | output | 1 | Registered interrupt output |
| irq_idx | output | 3 | Registered index of the winning line |
| req_pend | output | 8 | Request vector |
| in_svc | output | 8 | In-service vector |
| mask_q | output | 8 | Mask vector |
| trig_mode | output | 8 | Trigger-mode vector |
| prio_base | output | 3 | Current priority base |

## Verification
A wrong rank or rotation shows first on `irq_idx`, two clock edges after the stimulus: one edge to latch the request and one to register the decision. Wrong in-service bookkeeping appears one edge after an acknowledge or command on `in_svc`. It also has a visible effect on `irq_out`, which stays low when it should rise or rises when a nested request should be held back. A lost edge-mode history appears on `req_pend` one edge after the input changes, as a bit that returns while the line is held high.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int unsigned LINES = 8;
  localparam int unsigned IDX_W = $clog2(LINES);

  typedef enum logic [2:0] {
    OP_NONE         = 3'd0,
    OP_EOI_TOP      = 3'd1,
    OP_EOI_TOP_ROT  = 3'd2,
    OP_EOI_NAMED    = 3'd3,
    OP_EOI_NAMED_ROT= 3'd4,
    OP_SET_BASE     = 3'd5
  } cmd_op_e;

endpackage

// File: rtl/prio_scan.sv
// Rotating priority scanner: rank of the best set bit, N when empty.
module prio_scan #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] base,
  output logic [IW:0]   rank
);

  logic [N-1:0] rot;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rot
      assign rot[g] = vec[IW'(g) + base];
    end
  endgenerate

  always_comb begin
    rank = (IW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) begin
        rank = (IW+1)'(k);
      end
    end
  end

endmodule

// File: rtl/req_capture.sv
// Request latch: edge or level capture per line, cleared on acknowledge.
module req_capture #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic [N-1:0]  lvl_mode,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  output logic [N-1:0]  irr_q
);

  logic [N-1:0] last_q;
  logic [N-1:0] last_nxt;
  logic [N-1:0] irr_nxt;
  logic [N-1:0] rise;
  logic [N-1:0] ack_hit;

  always_comb begin
    rise     = req_in & ~last_q;
    ack_hit  = ack_valid ? (N'(1) << ack_idx) : '0;
    last_nxt = req_in;
    for (int i = 0; i < N; i++) begin
      if (lvl_mode[i]) begin
        irr_nxt[i] = req_in[i];
      end else begin
        irr_nxt[i] = (irr_q[i] & ~ack_hit[i]) | rise[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      irr_q  <= '0;
    end else begin
      last_q <= last_nxt;
      irr_q  <= irr_nxt;
    end
  end

  AST_LEVEL_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((irr_q ^ $past(req_in)) & $past(lvl_mode)) == '0)); // R3

  AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !lvl_mode[ack_idx] && !req_in[ack_idx])
      |=> ((irr_q & (N'(1) << $past(ack_idx))) == '0)); // R7

  AST_HELD_LINE_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irr_q[0] && !lvl_mode[0] && $past(req_in[0]) && req_in[0] && !ack_valid)
      |=> !irr_q[0]); // R2

endmodule

// File: rtl/svc_tracker.sv
// In-service vector and rotating base, driven by acknowledges and commands.
module svc_tracker
  import prio_irq_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  input  logic          auto_eoi,
  input  logic          rot_aeoi,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_idx,
  output logic [N-1:0]  isr_q,
  output logic [IW-1:0] base_q
);

  logic [N-1:0]  isr_nxt;
  logic [IW-1:0] base_nxt;
  logic [IW:0]   top_rank;
  logic          top_any;
  logic [IW-1:0] top_idx;
  cmd_op_e       op;

  prio_scan #(.N(N)) u_top_scan (
    .vec  (isr_q),
    .base (base_q),
    .rank (top_rank)
  );

  always_comb begin
    top_any  = !top_rank[IW];
    top_idx  = top_rank[IW-1:0] + base_q;
    op       = cmd_op_e'(cmd_op);
    isr_nxt  = isr_q;
    base_nxt = base_q;

    if (ack_valid) begin
      if (!auto_eoi) begin
        isr_nxt[ack_idx] = 1'b1;
      end else if (rot_aeoi) begin
        base_nxt = ack_idx + IW'(1);
      end
    end

    if (cmd_valid) begin
      case (op)
        OP_EOI_TOP: begin
          if (top_any) isr_nxt[top_idx] = 1'b0;
        end
        OP_EOI_TOP_ROT: begin
          if (top_any) begin
            isr_nxt[top_idx] = 1'b0;
            base_nxt         = top_idx + IW'(1);
          end
        end
        OP_EOI_NAMED: begin
          isr_nxt[cmd_idx] = 1'b0;
        end
        OP_EOI_NAMED_ROT: begin
          isr_nxt[cmd_idx] = 1'b0;
          base_nxt         = cmd_idx + IW'(1);
        end
        OP_SET_BASE: begin
          base_nxt = cmd_idx + IW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q  <= isr_nxt;
      base_q <= base_nxt;
    end
  end

  AST_TOP_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd1) && !ack_valid && (isr_q != '0))
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R9

  AST_AEOI_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && auto_eoi && rot_aeoi && !cmd_valid)
      |=> (base_q == $past(ack_idx) + IW'(1))); // R8

  AST_AEOI_KEEPS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && auto_eoi && !cmd_valid) |=> $stable(isr_q)); // R7

  AST_SET_BASE_KEEPS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd5) && !ack_valid) |=> $stable(isr_q)); // R10

endmodule

// File: rtl/prio_irq_resolver.sv
// Top: mask and trigger vectors, arbitration against in-service, output register.
module prio_irq_resolver #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned CASCADE_LINE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic          trig_we,
  input  logic [N-1:0]  trig_wdata,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_wdata,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_idx,
  input  logic          cfg_auto_eoi,
  input  logic          cfg_rot_aeoi,
  input  logic          cfg_special_mask,
  input  logic          cfg_nested,
  input  logic          cfg_master,
  output logic          irq_out,
  output logic [IW-1:0] irq_idx,
  output logic [N-1:0]  req_pend,
  output logic [N-1:0]  in_svc,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  trig_mode,
  output logic [IW-1:0] prio_base
);

  logic [N-1:0]  imr_q, imr_nxt;
  logic [N-1:0]  lvl_q, lvl_nxt;
  logic [N-1:0]  irr_w;
  logic [N-1:0]  isr_w;
  logic [IW-1:0] base_w;
  logic [N-1:0]  pend_vec;
  logic [N-1:0]  cur_vec;
  logic [IW:0]   pend_rank;
  logic [IW:0]   cur_rank;
  logic          fire;
  logic [IW-1:0] win_idx;
  logic          irq_q;
  logic [IW-1:0] idx_q, idx_nxt;

  req_capture #(.N(N)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (req_in),
    .lvl_mode  (lvl_q),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .irr_q     (irr_w)
  );

  svc_tracker #(.N(N)) u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .auto_eoi  (cfg_auto_eoi),
    .rot_aeoi  (cfg_rot_aeoi),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .isr_q     (isr_w),
    .base_q    (base_w)
  );

  always_comb begin
    pend_vec = irr_w & ~imr_q;
    cur_vec  = isr_w;
    if (cfg_special_mask) begin
      cur_vec = cur_vec & ~imr_q;
    end
    if (cfg_nested && cfg_master) begin
      cur_vec[CASCADE_LINE] = 1'b0;
    end
  end

  prio_scan #(.N(N)) u_pend_scan (
    .vec  (pend_vec),
    .base (base_w),
    .rank (pend_rank)
  );

  prio_scan #(.N(N)) u_cur_scan (
    .vec  (cur_vec),
    .base (base_w),
    .rank (cur_rank)
  );

  always_comb begin
    fire    = !pend_rank[IW] && (pend_rank < cur_rank);
    win_idx = pend_rank[IW-1:0] + base_w;
    idx_nxt = fire ? win_idx : idx_q;
    imr_nxt = mask_we ? mask_wdata : imr_q;
    lvl_nxt = trig_we ? trig_wdata : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= '0;
      lvl_q <= '0;
      irq_q <= 1'b0;
      idx_q <= '0;
    end else begin
      imr_q <= imr_nxt;
      lvl_q <= lvl_nxt;
      irq_q <= fire;
      idx_q <= idx_nxt;
    end
  end

  assign irq_out   = irq_q;
  assign irq_idx   = idx_q;
  assign req_pend  = irr_w;
  assign in_svc    = isr_w;
  assign mask_q    = imr_q;
  assign trig_mode = lvl_q;
  assign prio_base = base_w;

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(irr_w & ~imr_q) != '0)); // R5

  AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (($past(imr_q) & (N'(1) << idx_q)) == '0)); // R5

  AST_WINNER_NOT_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !$past(cfg_nested && cfg_master))
      |-> (($past(isr_w) & (N'(1) << idx_q)) == '0)); // R6

  AST_IDX_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> (idx_q == $past(idx_q))); // R13

endmodule

// File: tb/prio_irq_resolver_test.sv
module prio_irq_resolver_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_in;
  logic       trig_we, mask_we, ack_valid, cmd_valid;
  logic [7:0] trig_wdata, mask_wdata;
  logic [2:0] ack_idx, cmd_op, cmd_idx;
  logic       cfg_auto_eoi, cfg_rot_aeoi, cfg_special_mask, cfg_nested, cfg_master;
  logic       irq_out;
  logic [2:0] irq_idx, prio_base;
  logic [7:0] req_pend, in_svc, mask_q, trig_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_resolver uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in),
    .trig_we(trig_we), .trig_wdata(trig_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ack_valid(ack_valid), .ack_idx(ack_idx),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cfg_auto_eoi(cfg_auto_eoi), .cfg_rot_aeoi(cfg_rot_aeoi),
    .cfg_special_mask(cfg_special_mask), .cfg_nested(cfg_nested),
    .cfg_master(cfg_master),
    .irq_out(irq_out), .irq_idx(irq_idx),
    .req_pend(req_pend), .in_svc(in_svc), .mask_q(mask_q),
    .trig_mode(trig_mode), .prio_base(prio_base)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ack(input logic [2:0] idx);
    ack_valid = 1'b1; ack_idx = idx;
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] idx);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
    tick();
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    mask_we = 1'b1; mask_wdata = m;
    tick();
    mask_we = 1'b0;
  endtask

  task automatic set_trig(input logic [7:0] t);
    trig_we = 1'b1; trig_wdata = t;
    tick();
    trig_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 req_pend", req_pend, 8'h00);
    check("R1 in_svc", in_svc, 8'h00);
    check("R1 mask", mask_q, 8'h00);
    check("R1 trig", trig_mode, 8'h00);
    check("R1 base", prio_base, 3'd0);
    check("R1 irq_out", irq_out, 1'b0);
  endtask

  task automatic t_edge_nesting();
    req_in = 8'h24;
    tick();
    check("R2 edge latch", req_pend, 8'h24);
    check("R13 irq one edge late", irq_out, 1'b0);
    tick();
    check("R4 irq raised", irq_out, 1'b1);
    check("R4 lowest line wins", irq_idx, 3'd2);
    ack(3'd2);
    check("R7 edge bit cleared", req_pend, 8'h20);
    check("R7 in-service set", in_svc, 8'h04);
    tick();
    check("R2 held line not relatched", req_pend, 8'h20);
    tick();
    check("R6 lower rank held back", irq_out, 1'b0);
    check("R13 idx held while idle", irq_idx, 3'd2);
    cmd(3'd1, 3'd0);
    check("R9 top eoi clears line 2", in_svc, 8'h00);
    tick();
    check("R6 line 5 now wins", irq_out, 1'b1);
    check("R6 line 5 index", irq_idx, 3'd5);
    ack(3'd5);
    cmd(3'd1, 3'd0);
    req_in = 8'h00;
    tick(); tick();
    check("R9 cleanup svc", in_svc, 8'h00);
    cmd(3'd1, 3'd0);
    check("R9 top eoi with none set", in_svc, 8'h00);
  endtask

  task automatic t_level();
    set_trig(8'h08);
    check("R3 trig written", trig_mode, 8'h08);
    req_in = 8'h08;
    tick();
    check("R3 level high", req_pend, 8'h08);
    req_in = 8'h00;
    tick();
    check("R3 level low", req_pend, 8'h00);
    req_in = 8'h08;
    tick();
    ack(3'd3);
    check("R7 level bit kept", req_pend, 8'h08);
    check("R7 level in-service", in_svc, 8'h08);
    cmd(3'd3, 3'd3);
    check("R10 named eoi", in_svc, 8'h00);
    cmd(3'd6, 3'd4);
    check("R10 op6 no effect base", prio_base, 3'd0);
    req_in = 8'h00;
    tick();
    set_trig(8'h00);
    tick(); tick();
    check("R3 line released", req_pend, 8'h00);
  endtask

  task automatic t_mask_aeoi();
    set_mask(8'h01);
    req_in = 8'h01;
    tick();
    check("R5 masked line latched", req_pend, 8'h01);
    tick(); tick();
    check("R5 masked line silent", irq_out, 1'b0);
    set_mask(8'h00);
    tick();
    check("R5 unmasked fires", irq_out, 1'b1);
    check("R5 unmasked index", irq_idx, 3'd0);
    cfg_auto_eoi = 1'b1; cfg_rot_aeoi = 1'b1;
    ack(3'd0);
    check("R7 auto eoi no svc", in_svc, 8'h00);
    check("R8 base after auto rotate", prio_base, 3'd1);
    cfg_auto_eoi = 1'b0; cfg_rot_aeoi = 1'b0;
    req_in = 8'h00;
    tick();
  endtask

  task automatic t_rotate();
    req_in = 8'h03;
    tick(); tick();
    check("R4 base 1 prefers line 1", irq_idx, 3'd1);
    cmd(3'd5, 3'd7);
    check("R10 set base wraps", prio_base, 3'd0);
    tick();
    check("R4 base 0 prefers line 0", irq_idx, 3'd0);
    ack(3'd0);
    cmd(3'd2, 3'd0);
    check("R9 rotating eoi clears", in_svc, 8'h00);
    check("R9 rotating eoi base", prio_base, 3'd1);
    ack(3'd1);
    check("R7 svc line 1", in_svc, 8'h02);
    cmd(3'd4, 3'd1);
    check("R10 named rotate clears", in_svc, 8'h00);
    check("R10 named rotate base", prio_base, 3'd2);
    req_in = 8'h00;
    cmd(3'd5, 3'd7);
    tick();
  endtask

  task automatic t_special_mask();
    req_in = 8'h10;
    tick();
    ack(3'd4);
    req_in = 8'h50;
    tick(); tick();
    check("R6 line 6 below line 4", irq_out, 1'b0);
    cfg_special_mask = 1'b1;
    set_mask(8'h10);
    tick();
    check("R11 special mask lets 6 through", irq_out, 1'b1);
    check("R11 index", irq_idx, 3'd6);
    cfg_special_mask = 1'b0;
    set_mask(8'h00);
    ack(3'd6);
    cmd(3'd3, 3'd6);
    cmd(3'd3, 3'd4);
    req_in = 8'h00;
    tick();
    check("R11 cleanup", in_svc, 8'h00);
  endtask

  task automatic t_nested();
    cfg_master = 1'b1;
    req_in = 8'h04;
    tick();
    ack(3'd2);
    req_in = 8'h00;
    tick();
    req_in = 8'h04;
    tick(); tick();
    check("R12 off: same line held", irq_out, 1'b0);
    cfg_nested = 1'b1;
    tick(); tick();
    check("R12 cascade bit ignored", irq_out, 1'b1);
    check("R12 index", irq_idx, 3'd2);
    cfg_nested = 1'b0; cfg_master = 1'b0;
    req_in = 8'h00;
    ack(3'd2);
    cmd(3'd3, 3'd2);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_in = '0; trig_we = 0; mask_we = 0; ack_valid = 0; cmd_valid = 0;
    trig_wdata = '0; mask_wdata = '0; ack_idx = '0; cmd_op = '0; cmd_idx = '0;
    cfg_auto_eoi = 0; cfg_rot_aeoi = 0; cfg_special_mask = 0;
    cfg_nested = 0; cfg_master = 0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_edge_nesting();
    t_level();
    t_mask_aeoi();
    t_rotate();
    t_special_mask();
    t_nested();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule